// File: doc/BRIEF.md
# Line-Cycle Energy Integrator

This block sums per-sample power figures over a window whose length is a count of line half cycles rather than a count of clocks. A zero-crossing pulse, produced upstream, marks each half cycle. On every valid sample the block builds two per-sample quantities from three phases:
- a signed active total from the per-phase active power inputs;
- an apparent total from per-phase RMS voltage times RMS current products. A selectable formula decides how these products are combined, and each phase can be masked.

Both quantities are integrated over the same window, so the two results always cover identical stretches of line time.

When the programmed number of half cycles has elapsed, the block does four things:
- it latches both totals into result registers;
- it raises a completion flag;
- it pulls an active-low interrupt if enabled;
- it restarts the next window at once.

A swap mode bit reroutes the active total, as a magnitude, into the apparent accumulator. In that mode the active result reads zero. A small write port programs the half-cycle count, the mode word and the interrupt enable. A one-cycle read strobe acknowledges the flag.

Top module: `line_energy_integrator`

## Requirements
- R1: After reset both results are 0, done_flag is 0 and irq_n is 1.
- R2: Writing N to address 0 (16-bit unsigned) starts a window that closes on the N-th zero-crossing pulse. Results and flag update on that clock edge. N=0 disables accumulation and completion.
- R3: Accumulators saturate instead of wrapping. The apparent result clamps at 2^24-1. The signed active result clamps at 8388607 or -8388608.
- R4: Mode word at address 1: bits [1:0] formula, bits [4:2] phase enables for A, B and C (bit 2 is A), bit 5 swap. Formula 0 and the reserved values 2 and 3 give the apparent term as the sum of the enabled Vx*Ix products.
- R5: Formula 1 uses floor((Va+Vc)/2)*Ib as the phase B apparent product, so Vb has no effect.
- R6: A cleared phase enable removes that phase from both the apparent and the active totals.
- R7: With bit 5 clear, act_energy is the saturated signed sum of the enabled Pa+Pb+Pc over the valid samples of the window.
- R8: With bit 5 set, app_energy accumulates |Pa+Pb+Pc| of the enabled phases and act_energy is 0 at the close.
- R9: After a close the window reloads from the stored count and restarts with cleared accumulators. Results hold until the next close. A write to address 0 or 1 also restarts the window with cleared accumulators.
- R10: A close sets done_flag. irq_n is low exactly while done_flag is 1 and the enable at address 2, bit 0, is 1.
- R11: A cycle with stat_rd high and no close clears done_flag on the next edge, which releases irq_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | 0 half-cycle count, 1 mode word, 2 interrupt enable |
| wr_data | input | 16 | Write data |
| stat_rd | input | 1 | Status read strobe, clears done_flag |
| zx_i | input | 1 | One-cycle pulse per line zero crossing |
| smp_vld | input | 1 | Sample inputs valid this cycle |
| va | input | 8 | Phase A RMS voltage, unsigned |
| vb | input | 8 | Phase B RMS voltage, unsigned |
| vc | input | 8 | Phase C RMS voltage, unsigned |
| ia | input | 8 | Phase A RMS current, unsigned |
| ib | input | 8 | Phase B RMS current, unsigned |
| ic | input | 8 | Phase C RMS current, unsigned |
| pa | input | 18 | Phase A active power, signed |
| pb | input | 18 | Phase B active power, signed |
| pc | input | 18 | Phase C active power, signed |
| act_energy | output | 24 | Latched active energy, signed |
| app_energy | output | 24 | Latched apparent energy, unsigned |
| done_flag | output | 1 | Window completion flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that zx_i is a single-cycle pulse per crossing and that configuration writes happen between windows or are meant to restart one. The window-countdown and saturation properties depend on those assumptions. The stimulus drives every input on the falling clock edge and pulses zx_i for one cycle, always with smp_vld low. It rewrites the count or mode word only when a fresh window is intended. The swap-mode property relies on mode writes clearing the accumulators, and the bench never changes the mode in the middle of a window without that restart.

// File: rtl/lca_pkg.sv
package lca_pkg;
  localparam int CNT_W = 16;
  localparam int ACC_W = 24;

  localparam logic [1:0] ADDR_LEN  = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_IE   = 2'd2;

  typedef enum logic [1:0] {
    FM_SUM     = 2'd0,
    FM_SPLIT_B = 2'd1,
    FM_RSV2    = 2'd2,
    FM_RSV3    = 2'd3
  } fmode_e;

  typedef struct packed {
    logic       swap;
    logic [2:0] en;
    fmode_e     fmode;
  } mode_t;
endpackage

// File: rtl/lca_combine.sv
module lca_combine
  import lca_pkg::*;
#(
  parameter int V_W = 8,
  parameter int I_W = 8,
  parameter int P_W = 18,
  localparam int PROD_W    = V_W + I_W,
  localparam int APP_SUM_W = PROD_W + 2,
  localparam int ACT_SUM_W = P_W + 2
) (
  input  fmode_e                       fmode_i,
  input  logic [2:0]                   en_i,
  input  logic [V_W-1:0]               v_i [3],
  input  logic [I_W-1:0]               i_i [3],
  input  logic [P_W-1:0]               p_i [3],
  output logic [APP_SUM_W-1:0]         app_sum_o,
  output logic signed [ACT_SUM_W-1:0]  act_sum_o,
  output logic [ACT_SUM_W-1:0]         act_mag_o
);
  logic [V_W:0]               vmid_wide;
  logic [V_W-1:0]             vmid;
  logic [V_W-1:0]             veff     [3];
  logic [PROD_W-1:0]          app_term [3];
  logic signed [ACT_SUM_W-1:0] act_term [3];

  always_comb begin
    vmid_wide = ({1'b0, v_i[0]} + {1'b0, v_i[2]}) >> 1;
    vmid      = vmid_wide[V_W-1:0];
  end

  for (genvar ph = 0; ph < 3; ph++) begin : g_phase
    if (ph == 1) begin : g_mid
      assign veff[ph] = (fmode_i == FM_SPLIT_B) ? vmid : v_i[ph];
    end else begin : g_plain
      assign veff[ph] = v_i[ph];
    end
    assign app_term[ph] = en_i[ph] ? (PROD_W'(veff[ph]) * PROD_W'(i_i[ph])) : '0;
    assign act_term[ph] = en_i[ph] ? {{2{p_i[ph][P_W-1]}}, p_i[ph]} : '0;
  end

  always_comb begin
    app_sum_o = APP_SUM_W'(app_term[0]) + APP_SUM_W'(app_term[1]) + APP_SUM_W'(app_term[2]);
    act_sum_o = act_term[0] + act_term[1] + act_term[2];
    act_mag_o = act_sum_o[ACT_SUM_W-1] ? (~act_sum_o + 1'b1) : act_sum_o;
  end
endmodule

// File: rtl/lca_window.sv
module lca_window #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             zx_i,
  output logic             active_o,
  output logic             close_o
);
  logic [CNT_W-1:0] rem_q, rem_d;

  assign active_o = (rem_q != '0);
  assign close_o  = active_o && zx_i && (rem_q == CNT_W'(1)) && !load_i;

  always_comb begin
    rem_d = rem_q;
    if (load_i)                 rem_d = load_val_i;
    else if (close_o)           rem_d = reload_val_i;
    else if (active_o && zx_i)  rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  // R2: each crossing inside a window counts down by one
  p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && zx_i && !close_o && !load_i) |=> (rem_q == $past(rem_q) - 1'b1));

  // R9: a close reloads the stored count
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    close_o |=> (rem_q == $past(reload_val_i)));
endmodule

// File: rtl/lca_accum.sv
module lca_accum #(
  parameter int ACC_W  = 24,
  parameter int INC_W  = 20,
  parameter bit SIGNED = 1'b0,
  localparam int SUM_W = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             close_i,
  output logic [ACC_W-1:0] result_o
);
  localparam logic [ACC_W-1:0] UMAX = {ACC_W{1'b1}};
  localparam logic [ACC_W-1:0] SMAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SMIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] run_q, run_d, res_q, res_d, sat;
  logic [INC_W-1:0] inc_eff;
  logic [SUM_W-1:0] sum;

  assign inc_eff = add_i ? inc_i : '0;

  if (SIGNED) begin : g_signed
    always_comb begin
      sum = {run_q[ACC_W-1], run_q} + {{(SUM_W-INC_W){inc_eff[INC_W-1]}}, inc_eff};
      if (sum[SUM_W-1] != sum[SUM_W-2]) sat = sum[SUM_W-1] ? SMIN : SMAX;
      else                              sat = sum[ACC_W-1:0];
    end
    // R3: a positive sum pinned at the top stays there
    p_hold_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == SMAX && add_i && !inc_i[INC_W-1] && !clr_i && !close_i) |=> (run_q == SMAX));
  end else begin : g_unsigned
    always_comb begin
      sum = {1'b0, run_q} + {{(SUM_W-INC_W){1'b0}}, inc_eff};
      sat = sum[SUM_W-1] ? UMAX : sum[ACC_W-1:0];
    end
    // R3: an unsigned sum pinned at full scale stays there
    p_hold_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == UMAX && add_i && !clr_i && !close_i) |=> (run_q == UMAX));
  end

  always_comb begin
    run_d = sat;
    res_d = res_q;
    if (clr_i)        run_d = '0;
    else if (close_i) begin
      run_d = '0;
      res_d = sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      res_q <= '0;
    end else begin
      run_q <= run_d;
      res_q <= res_d;
    end
  end

  assign result_o = res_q;

  // R9: a restart or close leaves the running sum empty
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || close_i) |=> (run_q == '0));
endmodule

// File: rtl/line_energy_integrator.sv
module line_energy_integrator
  import lca_pkg::*;
#(
  parameter int V_W = 8,
  parameter int I_W = 8,
  parameter int P_W = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 stat_rd,
  input  logic                 zx_i,
  input  logic                 smp_vld,
  input  logic [V_W-1:0]       va,
  input  logic [V_W-1:0]       vb,
  input  logic [V_W-1:0]       vc,
  input  logic [I_W-1:0]       ia,
  input  logic [I_W-1:0]       ib,
  input  logic [I_W-1:0]       ic,
  input  logic [P_W-1:0]       pa,
  input  logic [P_W-1:0]       pb,
  input  logic [P_W-1:0]       pc,
  output logic [ACC_W-1:0]     act_energy,
  output logic [ACC_W-1:0]     app_energy,
  output logic                 done_flag,
  output logic                 irq_n
);
  localparam int APP_SUM_W = V_W + I_W + 2;
  localparam int ACT_SUM_W = P_W + 2;
  localparam int INC_W     = (APP_SUM_W > ACT_SUM_W) ? APP_SUM_W : ACT_SUM_W;

  // reset synchronizer: assert asynchronously, release on clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // configuration and status
  logic [CNT_W-1:0] len_q, len_d;
  mode_t            mode_q, mode_d;
  logic             ie_q, ie_d, flag_q, flag_d;
  logic             wr_len, wr_mode, wr_ie, restart;
  logic             win_active, win_close;

  assign wr_len  = wr_en && (wr_addr == ADDR_LEN);
  assign wr_mode = wr_en && (wr_addr == ADDR_MODE);
  assign wr_ie   = wr_en && (wr_addr == ADDR_IE);
  assign restart = wr_len || wr_mode;

  always_comb begin
    len_d  = wr_len  ? wr_data : len_q;
    mode_d = wr_mode ? mode_t'(wr_data[5:0]) : mode_q;
    ie_d   = wr_ie   ? wr_data[0] : ie_q;
    flag_d = flag_q;
    if (win_close)    flag_d = 1'b1;
    else if (stat_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      len_q  <= '0;
      mode_q <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      len_q  <= len_d;
      mode_q <= mode_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  assign done_flag = flag_q;
  assign irq_n     = ~(flag_q & ie_q);

  // half-cycle window
  lca_window #(.CNT_W(CNT_W)) win_i (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .load_i       (restart),
    .load_val_i   (wr_len ? wr_data : len_q),
    .reload_val_i (len_q),
    .zx_i         (zx_i),
    .active_o     (win_active),
    .close_o      (win_close)
  );

  // per-sample terms
  logic [V_W-1:0]              v_arr [3];
  logic [I_W-1:0]              i_arr [3];
  logic [P_W-1:0]              p_arr [3];
  logic [APP_SUM_W-1:0]        app_sum;
  logic signed [ACT_SUM_W-1:0] act_sum;
  logic [ACT_SUM_W-1:0]        act_mag;

  assign v_arr = '{va, vb, vc};
  assign i_arr = '{ia, ib, ic};
  assign p_arr = '{pa, pb, pc};

  lca_combine #(.V_W(V_W), .I_W(I_W), .P_W(P_W)) comb_i (
    .fmode_i   (mode_q.fmode),
    .en_i      (mode_q.en),
    .v_i       (v_arr),
    .i_i       (i_arr),
    .p_i       (p_arr),
    .app_sum_o (app_sum),
    .act_sum_o (act_sum),
    .act_mag_o (act_mag)
  );

  // routing into the accumulators
  logic             take;
  logic [INC_W-1:0] app_inc, act_inc;

  always_comb begin
    take    = smp_vld && win_active && !restart;
    app_inc = mode_q.swap ? INC_W'(act_mag) : INC_W'(app_sum);
    act_inc = INC_W'(act_sum);
  end

  lca_accum #(.ACC_W(ACC_W), .INC_W(INC_W), .SIGNED(1'b1)) act_acc_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .clr_i    (restart),
    .add_i    (take && !mode_q.swap),
    .inc_i    (act_inc),
    .close_i  (win_close),
    .result_o (act_energy)
  );

  lca_accum #(.ACC_W(ACC_W), .INC_W(INC_W), .SIGNED(1'b0)) app_acc_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .clr_i    (restart),
    .add_i    (take),
    .inc_i    (app_inc),
    .close_i  (win_close),
    .result_o (app_energy)
  );

  // R10: a close always leaves the flag raised
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    win_close |=> done_flag);

  // R11: an acknowledge without a close releases the interrupt
  p_ack_release_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (stat_rd && !win_close) |=> (irq_n && !done_flag));

  // R8: in swap mode the active result closes at zero
  p_swap_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (win_close && mode_q.swap) |=> (act_energy == '0));
endmodule

// File: tb/line_energy_integrator_tb_top.sv
module line_energy_integrator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        stat_rd = 1'b0;
  logic        zx_i = 1'b0;
  logic        smp_vld = 1'b0;
  logic [7:0]  va = '0, vb = '0, vc = '0, ia = '0, ib = '0, ic = '0;
  logic [17:0] pa = '0, pb = '0, pc = '0;
  logic [23:0] act_energy, app_energy;
  logic        done_flag, irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  line_energy_integrator dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_rd(stat_rd), .zx_i(zx_i), .smp_vld(smp_vld),
    .va(va), .vb(vb), .vc(vc), .ia(ia), .ib(ib), .ic(ic),
    .pa(pa), .pb(pb), .pc(pc),
    .act_energy(act_energy), .app_energy(app_energy),
    .done_flag(done_flag), .irq_n(irq_n)
  );

  // columns: mode, va, vb, vc, ia, ib, ic, pa, pb, pc, app per window, act per window
  localparam int NV = 6;
  localparam int TV [NV][12] = '{
    '{28, 10, 20, 30,   1,   2,   3,    5,   -3,   7,  840,   54},  // R4 R7
    '{29, 10, 99, 30,   4,   5,   6,  -10,  -10, -10, 1920, -180},  // R5
    '{20, 10, 20, 30,   4,   5,   6,  100, 1000, -50, 1320,  300},  // R6
    '{60, 10, 20, 30,   1,   2,   3, -100,  -20,   0,  720,    0},  // R8
    '{31,  1,  2,  3, 255, 255, 255,    0,    0,   0, 9180,    0},  // R4 reserved
    '{29, 11, 50, 20,   0,   2,   0,    1,    1,   1,  180,   18}   // R5 floor
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = d[15:0];
    step();
    wr_en = 1'b0;
  endtask

  task automatic ack();
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
  endtask

  task automatic zx();
    zx_i = 1'b1;
    step();
    zx_i = 1'b0;
  endtask

  task automatic feed(input int n);
    smp_vld = 1'b1;
    for (int k = 0; k < n; k++) step();
    smp_vld = 1'b0;
  endtask

  task automatic set_in(input int r[12]);
    va = r[1][7:0]; vb = r[2][7:0]; vc = r[3][7:0];
    ia = r[4][7:0]; ib = r[5][7:0]; ic = r[6][7:0];
    pa = r[7][17:0]; pb = r[8][17:0]; pc = r[9][17:0];
  endtask

  initial begin
    #(4 * 150000);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    check("R1 act", {8'd0, act_energy}, 0);
    check("R1 app", {8'd0, app_energy}, 0);
    check("R1 flag", {31'd0, done_flag}, 0);
    check("R1 irq", {31'd0, irq_n}, 1);
    rst_n = 1'b1;
    repeat (4) step();

    // table walk: two half cycles, three samples each
    for (int e = 0; e < NV; e++) begin
      set_in(TV[e]);
      wr(2'd1, TV[e][0]);
      wr(2'd0, 2);
      ack();
      feed(3); zx();
      check("R2 not yet", {31'd0, done_flag}, 0);
      feed(3); zx();
      check("R4-table app", {8'd0, app_energy}, TV[e][10] & 32'hFFFFFF);
      check("R7-table act", {8'd0, act_energy}, TV[e][11] & 32'hFFFFFF);
      check("R10 flag", {31'd0, done_flag}, 1);
    end

    // R9 automatic restart with cleared accumulators
    set_in(TV[0]);
    wr(2'd1, TV[0][0]);
    wr(2'd0, 1);
    feed(2); zx();
    check("R9 first app", {8'd0, app_energy}, 280);
    feed(1); zx();
    check("R9 restart app", {8'd0, app_energy}, 140);
    check("R9 restart act", {8'd0, act_energy}, 9);

    // R2 exact length of three
    ack();
    wr(2'd0, 3);
    zx(); zx();
    check("R2 two of three", {31'd0, done_flag}, 0);
    zx();
    check("R2 three of three", {31'd0, done_flag}, 1);

    // R2 zero length: no accumulation, no completion, results held
    ack();
    wr(2'd0, 0);
    feed(4); zx(); zx(); zx();
    check("R2 zero flag", {31'd0, done_flag}, 0);
    check("R2 zero held", {8'd0, app_energy}, 0);

    // R10 / R11 interrupt behaviour
    wr(2'd2, 1);
    wr(2'd0, 1);
    check("R10 idle irq", {31'd0, irq_n}, 1);
    feed(1); zx();
    check("R10 irq low", {31'd0, irq_n}, 0);
    ack();
    check("R11 flag cleared", {31'd0, done_flag}, 0);
    check("R11 irq released", {31'd0, irq_n}, 1);
    wr(2'd2, 0);
    feed(1); zx();
    check("R10 masked flag", {31'd0, done_flag}, 1);
    check("R10 masked irq", {31'd0, irq_n}, 1);

    // R3 saturation, positive
    va = 8'd255; vb = 8'd255; vc = 8'd255; ia = 8'd255; ib = 8'd255; ic = 8'd255;
    pa = 18'h1FFFF; pb = 18'h1FFFF; pc = 18'h1FFFF;
    wr(2'd1, 28);
    wr(2'd0, 1);
    feed(100); zx();
    check("R3 app clamp", {8'd0, app_energy}, 32'hFFFFFF);
    check("R3 act clamp hi", {8'd0, act_energy}, 32'h7FFFFF);
    // R3 saturation, negative
    pa = 18'h20000; pb = 18'h20000; pc = 18'h20000;
    feed(100); zx();
    check("R3 act clamp lo", {8'd0, act_energy}, 32'h800000);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule